// File: doc/BRIEF.md
# Interrupt-Capable Eight-Bit Parallel Port

This block is an eight-pin general-purpose port for a larger chip. Software programs it through a small 16-bit register bus. Each pin can be an output that drives a stored value, or an input whose level is read back. Every pin also has a pullup-enable control that goes to the pad, which sits outside this block. The port has no alternate-function multiplexing, so the pins are always in plain I/O mode.

Input pins can request an interrupt. Each pin selects level or edge sensing, an active polarity and an enable bit. The active polarity is applied by inverting the synchronized input before anything else sees it. An edge event is latched and reads back as a one in the data register; software clears it by writing a one to that bit. The single request line is the OR of every enabled pending condition, and it goes to an interrupt controller that is not part of this block.

Pin inputs pass through a two-stage synchronizer. An input change therefore appears in level reads and level interrupts two clocks later, and as a latched edge event three clocks later.

Top module: `pio8_port`

## Requirements
- R1: After reset, the direction, data-store, polarity, interrupt-enable and edge-enable registers are all zero and the pullup register is 0x00FF. As a result `pin_oe` is 0x00, `pin_pu` is 0xFF and `irq` is low. Bus word 5 and above read as 0.
- R2: `pin_oe` equals the direction register (word 0, bits 7:0, 1 = output), one clock after the register is written.
- R3: A write to the data word (word 1) is stored even when the pins are inputs. `pin_out` carries the stored value, and that value reaches the pad only once `pin_oe` sets the bit.
- R4: For a pin set as output, reading word 1 returns the synchronized pin level, not the stored value.
- R5: For an input pin in level mode, word 1 reads the synchronized pin XOR its polarity bit, two clocks after the pin changes.
- R6: An input pin in level mode with its enable bit set raises `irq` while its polarity-adjusted level is 1. Output pins never raise `irq`.
- R7: An input pin in edge mode latches an event on a rising pin when its polarity bit is 0, or on a falling pin when its polarity bit is 1. The event reads as 1 in word 1 three clocks after the pin change, and a pin change in the opposite direction latches nothing.
- R8: Writing 1 to a data bit clears that pin's latched event. Writing 0 leaves it set.
- R9: A pin whose interrupt-enable bit is 0 never drives `irq`, but its latched event is kept. Setting the enable bit later raises `irq` on the next clock.
- R10: Word 3 holds the polarity bits in bits 15:8 and the interrupt-enable bits in bits 7:0. Word 4 holds the edge-enable bits in bits 7:0, and its bits 15:8 always read 0. Word 2 is the pullup register.
- R11: `pin_pu` follows the pullup register (1 = pullup on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word (combinational) |
| pin_in | input | 8 | Levels seen at the pads |
| pin_out | output | 8 | Stored output values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pullup enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a polarity-inverted edge event that survives while masked and is then released. To get there, the bench first parks the pin high and sets the polarity and enable while edge sensing is still off, so the change of polarity cannot itself look like an edge. Only then does it turn on edge sensing and drop the pin. It then confirms that a rising pin latches nothing, that writing zeros leaves the event in place, and that setting the enable bit alone raises the request.

// File: rtl/pio8_pkg.sv
package pio8_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_PULL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EDGE = 3'd4;
endpackage

// File: rtl/pio8_sync.sv
module pio8_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio8_regs.sv
module pio8_regs
  import pio8_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned DW = 2 * N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N-1:0]      pin_sync,
  input  logic [N-1:0]      cond,
  input  logic [N-1:0]      evt,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      dout_q,
  output logic [N-1:0]      pull_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      ien_q,
  output logic [N-1:0]      edge_q,
  output logic [N-1:0]      clr,
  output logic [DW-1:0]     rdata
);
  logic [N-1:0] dir_n, dout_n, pull_n, pol_n, ien_n, edge_n;
  logic [N-1:0] data_rd;

  always_comb begin
    dir_n  = dir_q;
    dout_n = dout_q;
    pull_n = pull_q;
    pol_n  = pol_q;
    ien_n  = ien_q;
    edge_n = edge_q;
    if (wr) begin
      case (addr)
        A_DIR:  dir_n  = wdata[N-1:0];
        A_DATA: dout_n = wdata[N-1:0];
        A_PULL: pull_n = wdata[N-1:0];
        A_CFG:  begin
          pol_n = wdata[DW-1:N];
          ien_n = wdata[N-1:0];
        end
        A_EDGE: edge_n = wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      pull_q <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
    end else begin
      dir_q  <= dir_n;
      dout_q <= dout_n;
      pull_q <= pull_n;
      pol_q  <= pol_n;
      ien_q  <= ien_n;
      edge_q <= edge_n;
    end
  end

  assign clr = (wr && addr == A_DATA) ? wdata[N-1:0] : '0;

  assign data_rd = (dir_q & pin_sync)
                 | (~dir_q & edge_q & evt)
                 | (~dir_q & ~edge_q & cond);

  always_comb begin
    case (addr)
      A_DIR:   rdata = {{N{1'b0}}, dir_q};
      A_DATA:  rdata = {{N{1'b0}}, data_rd};
      A_PULL:  rdata = {{N{1'b0}}, pull_q};
      A_CFG:   rdata = {pol_q, ien_q};
      A_EDGE:  rdata = {{N{1'b0}}, edge_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio8_evt.sv
module pio8_evt #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] edge_en,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt_q,
  output logic         irq
);
  logic [N-1:0] prev_q, evt_n, rise, lvl;

  assign rise  = cond & ~prev_q;
  assign evt_n = ((evt_q & ~clr) | rise) & edge_en & ~dir;
  assign lvl   = cond & ~edge_en & ~dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= cond;
      evt_q  <= evt_n;
    end
  end

  assign irq = |(ien & (evt_q | lvl));
endmodule

// File: rtl/pio8_port.sv
module pio8_port
  import pio8_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned DW = 2 * N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic [N-1:0]      pin_pu,
  output logic              irq
);
  logic [1:0]   rst_pipe_q;
  logic         rst_n_sync;
  logic [N-1:0] pin_sync, cond;
  logic [N-1:0] dir_q, dout_q, pull_q, pol_q, ien_q, edge_q, clr, evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  pio8_sync #(.W(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .d(pin_in), .q(pin_sync)
  );

  assign cond = pin_sync ^ pol_q;

  pio8_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync), .cond(cond), .evt(evt_q),
    .dir_q(dir_q), .dout_q(dout_q), .pull_q(pull_q), .pol_q(pol_q),
    .ien_q(ien_q), .edge_q(edge_q), .clr(clr), .rdata(bus_rdata)
  );

  pio8_evt #(.N(N)) u_evt (
    .clk(clk), .rst_n(rst_n_sync), .cond(cond), .dir(dir_q),
    .edge_en(edge_q), .ien(ien_q), .clr(clr), .evt_q(evt_q), .irq(irq)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign pin_pu  = pull_q;
endmodule

// File: rtl/pio8_port_chk.sv
module pio8_port_chk
  import pio8_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned DW = 2 * N
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [N-1:0]      pin_oe,
  input logic [N-1:0]      pin_pu,
  input logic              irq,
  input logic [N-1:0]      ien_q,
  input logic [N-1:0]      edge_q,
  input logic [N-1:0]      evt_q
);
  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata[N-1:0]))); // R2

  AST_PU_TRACKS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PULL) |=> (pin_pu == $past(bus_wdata[N-1:0]))); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R9

  AST_EVT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & ~$past(edge_q)) == '0)); // R7

  AST_EDGE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_EDGE) |-> (bus_rdata[DW-1:N] == '0)); // R10
endmodule

bind pio8_port pio8_port_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
  .pin_pu(pin_pu), .irq(irq), .ien_q(ien_q), .edge_q(edge_q), .evt_q(evt_q)
);

// File: tb/pio8_port_tb.sv
`timescale 1ns/1ps
module pio8_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_pu;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pio8_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .irq(irq)
  );

  // {dir, pol, ien, pin, expected data read, expected irq}, level mode
  localparam logic [40:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 8'hA5, 8'hA5, 1'b0},
    {8'h00, 8'hFF, 8'h01, 8'hA5, 8'h5A, 1'b0},
    {8'h00, 8'hFF, 8'h02, 8'hA5, 8'h5A, 1'b1},
    {8'hF0, 8'h0F, 8'hF0, 8'h3C, 8'h33, 1'b0},
    {8'hF0, 8'h0F, 8'h0C, 8'h3C, 8'h33, 1'b0},
    {8'h0F, 8'h00, 8'h80, 8'h80, 8'h80, 1'b1},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h81, 8'h81, 8'h7E, 8'hFF, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 dir", v, 16'h0000);
    rd(3'd1, v); check("R1 data", v, 16'h0000);
    rd(3'd2, v); check("R1 pull", v, 16'h00FF);
    rd(3'd3, v); check("R1 cfg", v, 16'h0000);
    rd(3'd4, v); check("R1 edge", v, 16'h0000);
    rd(3'd5, v); check("R1 unused word", v, 16'h0000);
    check("R1 oe", {8'h00, pin_oe}, 16'h0000);
    check("R1 pu", {8'h00, pin_pu}, 16'h00FF);
    check("R1 irq", {15'h0, irq}, 16'h0000);

    // R4 R5 R6: level-mode vector table
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {8'h00, VEC[i][40:33]});
      wr(3'd3, {VEC[i][32:25], VEC[i][24:17]});
      pin_in = VEC[i][16:9];
      settle();
      rd(3'd1, v);
      check("R5 R4 vector read", v, {8'h00, VEC[i][8:1]});
      check("R6 vector irq", {15'h0, irq}, {15'h0, VEC[i][0]});
    end

    // R10 layout
    wr(3'd3, 16'hABCD); rd(3'd3, v); check("R10 cfg layout", v, 16'hABCD);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); check("R10 edge upper zero", v, 16'h00FF);
    wr(3'd4, 16'h0000); wr(3'd3, 16'h0000);

    // R11 pullups
    wr(3'd2, 16'h000F); check("R11 pu", {8'h00, pin_pu}, 16'h000F);

    // R3 R2 R4 stored data while input, then driven
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h005A);
    check("R3 oe still off", {8'h00, pin_oe}, 16'h0000);
    wr(3'd0, 16'h00FF);
    check("R2 oe", {8'h00, pin_oe}, 16'h00FF);
    check("R3 out", {8'h00, pin_out}, 16'h005A);
    pin_in = 8'h00; settle();
    rd(3'd1, v); check("R4 reads pin not store", v, 16'h0000);
    wr(3'd0, 16'h0000);

    // R7 R8 rising edge on bit 0
    pin_in = 8'h00;
    wr(3'd3, 16'h0001); wr(3'd4, 16'h0001); settle();
    rd(3'd1, v); check("R7 no event yet", v, 16'h0000);
    check("R7 irq idle", {15'h0, irq}, 16'h0000);
    pin_in = 8'h01; settle();
    rd(3'd1, v); check("R7 rise latched", v, 16'h0001);
    check("R7 irq on event", {15'h0, irq}, 16'h0001);
    pin_in = 8'h00; settle();
    rd(3'd1, v); check("R7 event held", v, 16'h0001);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R8 zero keeps event", v, 16'h0001);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); check("R8 one clears event", v, 16'h0000);
    check("R8 irq cleared", {15'h0, irq}, 16'h0000);

    // R7 falling edge with inverted polarity on bit 1
    wr(3'd4, 16'h0000);
    pin_in = 8'h02; settle();
    wr(3'd3, 16'h0202); settle();
    wr(3'd4, 16'h0002); settle();
    rd(3'd1, v); check("R7 inverted idle", v, 16'h0000);
    pin_in = 8'h00; settle();
    rd(3'd1, v); check("R7 fall latched", v, 16'h0002);
    check("R7 fall irq", {15'h0, irq}, 16'h0001);
    wr(3'd1, 16'h0002);
    pin_in = 8'h02; settle();
    rd(3'd1, v); check("R7 rise ignored when inverted", v, 16'h0000);

    // R9 masked event kept, then released
    wr(3'd3, 16'h0200);
    pin_in = 8'h00; settle();
    rd(3'd1, v); check("R9 event kept while masked", v, 16'h0002);
    check("R9 irq masked", {15'h0, irq}, 16'h0000);
    wr(3'd3, 16'h0202);
    check("R9 irq after enable", {15'h0, irq}, 16'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule